// File: doc/BRIEF.md
# Masked BSSID Receive Filter

This block decides whether a receiver should take and acknowledge an incoming frame. It compares the frame's 48-bit BSSID with the station's own MAC address. Only the bit positions that a programmable 48-bit mask enables take part in the comparison. Because the mask is shared by both operands, several virtual BSSes derived from one MAC address can pass a single filter. The filter is deliberately loose: a foreign BSSID that agrees on every enabled bit is accepted as well.

Software loads the MAC address and the mask through a 32-bit register-write port. Each address is split into a lower 32-bit word and an upper 16-bit word. A hardware helper can also build the mask. The helper is cleared to all ones, each served BSSID is pushed into it, and a load strobe then copies the result into the live mask. Each frame presents its BSSID with a valid strobe. One clock later the block returns an accept flag with its own valid strobe.

Top module: `bssid_filter`

## Requirements
- R1: When `frm_valid_i` is high, the accept flag is 1 exactly when `(bssid & mask) == (mask & mac)`; otherwise it is 0.
- R2: After reset, the mask is all ones, the MAC address is all zeros, the builder accumulator is all ones, and `acc_valid_o` and `acc_o` are 0.
- R3: `wr_sel_i` selects the register: 0 = MAC low word, 1 = MAC high word, 2 = mask low word, 3 = mask high word. A low word holds address bits [31:0], so address byte 0 sits in bits [7:0]. A high word takes `wr_data_i[15:0]` as address bits [47:32].
- R4: A write to the mask high word is only staged and leaves the live mask unchanged. The staged value goes live together with the next mask low-word write.
- R5: With an all-ones mask, a frame is accepted only if its BSSID equals the MAC address in all 48 bits.
- R6: Bits that are cleared in the mask never affect the result. With a zero mask, every frame is accepted.
- R7: `acc_valid_o` is `frm_valid_i` delayed by exactly one clock. When `acc_valid_o` is 0, `acc_o` is 0.
- R8: `bld_clear_i` sets the accumulator to all ones. Each `bld_push_i` ANDs `~(mac ^ bld_bssid_i)` into the accumulator, and `bld_mask_o` shows its value.
- R9: `bld_load_i` copies the accumulator into the whole live mask in one clock, and the staged high word takes the same value. A register write in the same cycle takes priority, and the load is dropped.
- R10: When `bld_clear_i` and `bld_push_i` are both high in one cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (see R3) |
| wr_data_i | input | 32 | Register write data |
| bld_clear_i | input | 1 | Reset the mask accumulator to all ones |
| bld_push_i | input | 1 | Fold `bld_bssid_i` into the accumulator |
| bld_bssid_i | input | 48 | Served BSSID for the builder |
| bld_load_i | input | 1 | Copy the accumulator into the live mask |
| bld_mask_o | output | 48 | Current accumulator value |
| frm_valid_i | input | 1 | Frame BSSID valid |
| frm_bssid_i | input | 48 | Frame BSSID, byte 0 in bits [7:0] |
| acc_valid_o | output | 1 | Accept result valid |
| acc_o | output | 1 | Accept flag |

## Verification
A corrupted mask or MAC bit shows up as a wrong accept flag on the very next frame whose BSSID differs from the MAC address at that position. The bench therefore flips, one at a time, bits in every byte lane and in both words. A staging fault in the high mask word shows only after a write to the high word alone, so that sequence is tested both before and after its paired low-word write. An accumulator fault is visible on `bld_mask_o` one clock after the push or clear that caused it, and again in the frames that follow a load.

// File: rtl/bssid_filt_pkg.sv
package bssid_filt_pkg;
  typedef enum logic [1:0] {
    REG_MAC_LO  = 2'd0,
    REG_MAC_HI  = 2'd1,
    REG_MASK_LO = 2'd2,
    REG_MASK_HI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bf_addr_regs.sv
module bf_addr_regs
  import bssid_filt_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_mask_i,
  output logic [ADDR_W-1:0] mac_o,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int HI_W = ADDR_W - WORD_W;

  logic [ADDR_W-1:0] mac_q, mask_q;
  logic [HI_W-1:0]   mask_hi_stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mac_q           <= '0;
      mask_q          <= '1;
      mask_hi_stage_q <= '1;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        REG_MAC_LO:  mac_q[WORD_W-1:0]      <= wr_data_i;
        REG_MAC_HI:  mac_q[ADDR_W-1:WORD_W] <= wr_data_i[HI_W-1:0];
        REG_MASK_HI: mask_hi_stage_q        <= wr_data_i[HI_W-1:0];
        default:     mask_q                 <= {mask_hi_stage_q, wr_data_i};
      endcase
    end else if (load_i) begin
      // keep the stage aligned so a later low-only write preserves the loaded high word
      mask_q          <= load_mask_i;
      mask_hi_stage_q <= load_mask_i[ADDR_W-1:WORD_W];
    end
  end

  assign mac_o  = mac_q;
  assign mask_o = mask_q;

  p_hi_staged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == REG_MASK_HI) |=> $stable(mask_o));

  p_wr_over_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == REG_MASK_LO && load_i) |=> mask_o[WORD_W-1:0] == $past(wr_data_i));

  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_en_i) |=> mask_o == $past(load_mask_i));

  p_mac_no_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_en_i) |=> $stable(mac_o));
endmodule

// File: rtl/bf_mask_builder.sv
module bf_mask_builder #(
  parameter int ADDR_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mac_i,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] bssid_i,
  output logic [ADDR_W-1:0] acc_o
);
  logic [ADDR_W-1:0] acc_q;
  logic [ADDR_W-1:0] agree;

  assign agree = ~(mac_i ^ bssid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '1;
    else if (clear_i) acc_q <= '1;
    else if (push_i)  acc_q <= acc_q & agree;
  end

  assign acc_o = acc_q;

  p_clear_ones_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (&acc_o));

  p_push_shrinks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i) |=> ((acc_o & ~$past(acc_o)) == '0));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !clear_i) |=> $stable(acc_o));
endmodule

// File: rtl/bf_masked_cmp.sv
module bf_masked_cmp #(
  parameter int ADDR_W = 48,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mac_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              frm_valid_i,
  input  logic [ADDR_W-1:0] frm_bssid_i,
  output logic              acc_valid_o,
  output logic              acc_o
);
  localparam int LANES = ADDR_W / LANE_W;

  logic [LANES-1:0] lane_ok;
  logic valid_q, acc_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ok[l] = ((frm_bssid_i[l*LANE_W +: LANE_W] ^ mac_i[l*LANE_W +: LANE_W])
                         & mask_i[l*LANE_W +: LANE_W]) == '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      valid_q <= frm_valid_i;
      acc_q   <= frm_valid_i & (&lane_ok);
    end
  end

  assign acc_valid_o = valid_q;
  assign acc_o       = acc_q;

  p_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> acc_valid_o);

  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> (!acc_valid_o && !acc_o));

  p_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && (&mask_i)) |=> (acc_o == ($past(frm_bssid_i) == $past(mac_i))));

  p_zero_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && mask_i == '0) |=> acc_o);

  p_own_mac_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && frm_bssid_i == mac_i) |=> acc_o);
endmodule

// File: rtl/bssid_filter.sv
module bssid_filter #(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              bld_clear_i,
  input  logic              bld_push_i,
  input  logic [ADDR_W-1:0] bld_bssid_i,
  input  logic              bld_load_i,
  output logic [ADDR_W-1:0] bld_mask_o,
  input  logic              frm_valid_i,
  input  logic [ADDR_W-1:0] frm_bssid_i,
  output logic              acc_valid_o,
  output logic              acc_o
);
  logic [ADDR_W-1:0] mac, mask, bld_acc;

  bf_addr_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .load_i      (bld_load_i),
    .load_mask_i (bld_acc),
    .mac_o       (mac),
    .mask_o      (mask)
  );

  bf_mask_builder #(.ADDR_W(ADDR_W)) u_bld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mac_i   (mac),
    .clear_i (bld_clear_i),
    .push_i  (bld_push_i),
    .bssid_i (bld_bssid_i),
    .acc_o   (bld_acc)
  );

  bf_masked_cmp #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mac_i       (mac),
    .mask_i      (mask),
    .frm_valid_i (frm_valid_i),
    .frm_bssid_i (frm_bssid_i),
    .acc_valid_o (acc_valid_o),
    .acc_o       (acc_o)
  );

  assign bld_mask_o = bld_acc;
endmodule

// File: tb/bssid_filter_tb.sv
`timescale 1ns/1ps
module bssid_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        b_clear = 1'b0, b_push = 1'b0, b_load = 1'b0;
  logic [47:0] b_bssid = '0;
  logic [47:0] b_mask;
  logic        f_valid = 1'b0;
  logic [47:0] f_bssid = '0;
  logic        a_valid, a_acc;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bssid_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .bld_clear_i(b_clear), .bld_push_i(b_push), .bld_bssid_i(b_bssid),
    .bld_load_i(b_load), .bld_mask_o(b_mask),
    .frm_valid_i(f_valid), .frm_bssid_i(f_bssid),
    .acc_valid_o(a_valid), .acc_o(a_acc)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic ref_acc(input logic [47:0] b, m, mac);
    return (b & m) == (m & mac);
  endfunction

  // spreads 8 index bits over every byte lane and both words
  function automatic logic [47:0] spread(input logic [7:0] i);
    logic [47:0] r = '0;
    r[0] = i[0]; r[7] = i[1]; r[8] = i[2]; r[23] = i[3];
    r[31] = i[4]; r[32] = i[5]; r[40] = i[6]; r[47] = i[7];
    return r;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_mac(input logic [47:0] m);
    wr(2'd0, m[31:0]); wr(2'd1, {16'h0, m[47:32]});
  endtask

  task automatic set_mask(input logic [47:0] m);
    wr(2'd3, {16'h0, m[47:32]}); wr(2'd2, m[31:0]);
  endtask

  task automatic frame(input logic [47:0] b, output logic v, output logic a);
    @(negedge clk); f_valid = 1'b1; f_bssid = b;
    @(negedge clk); v = a_valid; a = a_acc; f_valid = 1'b0;
  endtask

  task automatic frm_chk(input logic [47:0] b, input logic exp, input string req);
    logic v, a;
    frame(b, v, a);
    chk(v === 1'b1 && a === exp, req, {46'h0, v, a}, {46'h0, 1'b1, exp});
  endtask

  task automatic bpush(input logic [47:0] b);
    @(negedge clk); b_push = 1'b1; b_bssid = b;
    @(negedge clk); b_push = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] mac, m, b, b1, b2, exp_m;
    logic [47:0] masks [4];

    repeat (3) @(negedge clk);
    // R2 reset state
    chk(a_valid === 1'b0 && a_acc === 1'b0, "R2 outputs", {46'h0, a_valid, a_acc}, 48'h0);
    chk(b_mask === '1, "R2 accumulator", b_mask, '1);
    rst_n = 1'b1;
    frm_chk(48'h0, 1'b1, "R2 zero mac");
    frm_chk(48'h1, 1'b0, "R2 full mask");
    // R7 idle after a frame
    @(negedge clk);
    chk(a_valid === 1'b0 && a_acc === 1'b0, "R7 idle", {46'h0, a_valid, a_acc}, 48'h0);

    // R3 register map and byte order
    wr(2'd0, 32'h0403_0201); wr(2'd1, 32'hABCD_0605);
    frm_chk(48'h0605_0403_0201, 1'b1, "R3 byte order");
    frm_chk(48'h0102_0304_0506, 1'b0, "R3 reversed");

    // R5 single-bit flips with full mask
    mac = 48'h0605_0403_0201;
    for (int i = 0; i < 48; i++) frm_chk(mac ^ (48'h1 << i), 1'b0, "R5 flip");

    // R4 high word staged
    wr(2'd3, 32'h0);
    frm_chk(mac ^ 48'h8000_0000_0000, 1'b0, "R4 staged");
    wr(2'd2, 32'hFFFF_FFFF);
    frm_chk(mac ^ 48'h8000_0000_0000, 1'b1, "R4 committed");
    frm_chk(mac ^ 48'h1, 1'b0, "R4 low live");

    // R6 zero mask
    set_mask(48'h0);
    frm_chk(48'hFFFF_FFFF_FFFF, 1'b1, "R6 zero mask");
    frm_chk(48'h1234_5678_9ABC, 1'b1, "R6 zero mask");

    // R1 sweep over masks and spread patterns
    mac = 48'h5A3C_96E1_0F72;
    set_mac(mac);
    masks[0] = '1;
    masks[1] = 48'hFF00_FFFF_00FF;
    masks[2] = 48'h8001_8000_0081;
    masks[3] = 48'h0000_0000_0000;
    for (int k = 0; k < 4; k++) begin
      m = masks[k];
      set_mask(m);
      for (int i = 0; i < 256; i++) begin
        b = mac ^ spread(i[7:0]) ^ (~m & 48'hA5A5_5A5A_C3C3);
        frm_chk(b, ref_acc(b, m, mac), "R1 sweep");
      end
    end

    // R8 builder, small virtual-BSS set
    mac = 48'h0000_0000_0001; b1 = 48'h4; b2 = 48'h9;
    set_mac(mac);
    @(negedge clk); b_clear = 1'b1; @(negedge clk); b_clear = 1'b0;
    chk(b_mask === '1, "R8 clear", b_mask, '1);
    bpush(b1);
    exp_m = ~(mac ^ b1);
    chk(b_mask === exp_m, "R8 push1", b_mask, exp_m);
    bpush(b2);
    exp_m = exp_m & ~(mac ^ b2);
    chk(b_mask === exp_m, "R8 push2", b_mask, exp_m);

    // R9 load
    @(negedge clk); b_load = 1'b1; @(negedge clk); b_load = 1'b0;
    frm_chk(b1, 1'b1, "R9 served1");
    frm_chk(b2, 1'b1, "R9 served2");
    frm_chk(mac, 1'b1, "R9 mac");
    frm_chk(48'h6, 1'b0, "R9 foreign");
    frm_chk(48'hD, 1'b1, "R6 foreign passes");
    // R9 write beats load: mask becomes {FFFF, 0}
    @(negedge clk); b_load = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h0;
    @(negedge clk); b_load = 1'b0; wr_en = 1'b0;
    frm_chk(mac ^ 48'h2, 1'b1, "R9 write priority");
    frm_chk(mac ^ (48'h1 << 40), 1'b0, "R9 high kept");

    // R10 clear beats push
    bpush(48'hFFFF_0000_FFFF);
    @(negedge clk); b_clear = 1'b1; b_push = 1'b1; b_bssid = 48'h0F0F_0F0F_0F0F;
    @(negedge clk); b_clear = 1'b0; b_push = 1'b0;
    chk(b_mask === '1, "R10 clear wins", b_mask, '1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule